// File: doc/BRIEF.md
# Strobed Nibble Register Loader

This block is the programming front end of a clock generator. A host shares one 4-bit bus between address and data and drives a single strobe line. A falling strobe edge takes a register address from the bus, and the rising edge that follows takes the data nibble for that register. The strobe is sampled in the system clock domain, so each write also raises a one-cycle pulse that carries the address and data.

Writes land in sixteen nibble-wide shadow locations. The block holds the outputs seen by the rest of the clock generator at a defined power-on pattern until a fixed number of writes has been counted. After that count is reached, those outputs follow the shadow locations, and every later write takes effect at once.

The block also drives a phase-detector disable output. Once a particular enable bit is set, that output follows bus bit 3 directly, with no strobe, whenever the last address taken was 15.

Top module: `nibld_top`

## Requirements
- R1: A falling strobe edge takes the address from bus_i[3:0]. The next rising edge takes the data from bus_i[3:0] and completes the write. A rising edge with no falling edge before it writes nothing.
- R2: Each completed write drives wr_valid_o high for exactly one clock cycle, carrying that write's address and data. With the strobe changed half a cycle before a clock edge, the pulse is present in the third clock cycle after the rising strobe change and absent in the cycles either side of it.
- R3: From reset until the write count reaches UNLOCK_WRITES (default 32), act_regs_o shows the power-on pattern. Slot k occupies bits [4k+3:4k]. Slot 5 is 4'b0001, which selects a divide-by-four load-clock modulus. Slot 12 is 4'b1000, whose bit 3 routes the reference clock to the main output. Every other slot is 4'b0000.
- R4: From the write that brings the count to UNLOCK_WRITES onward, every stored slot of act_regs_o shows its shadow value. The change becomes visible one clock cycle after that write's wr_valid_o pulse.
- R5: The write count saturates at UNLOCK_WRITES. The unlocked condition is sticky and only rst clears it.
- R6: Addresses 13 and 14 have no storage. Writes to them are counted and pulsed but discarded, and their slots always read 4'b0000.
- R7: Address 10 is a reserved slot. It is stored and shown on act_regs_o like any other stored slot.
- R8: pd_dis_o is high exactly when act_regs_o slot 15 bit 3 is set, the last address taken was 15, and bus_i[3] is high. It follows bus_i combinationally, with no strobe.
- R9: rst clears the write count and restores the power-on pattern but leaves the shadow contents alone. After the next unlock, a slot that was not rewritten shows the value it held before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Asynchronous write strobe, idle high |
| bus_i | input | 4 | Shared address/data nibble bus |
| act_regs_o | output | 64 | Active register slots, slot k at bits [4k+3:4k] |
| pd_dis_o | output | 1 | Phase-detector disable |
| wr_valid_o | output | 1 | One-cycle pulse on each completed write |
| wr_addr_o | output | 4 | Address of the completed write |
| wr_data_o | output | 4 | Data of the completed write |

## Verification
The bench changes the strobe at a falling clock edge. The change passes two synchroniser flops and then the capture register, so the write pulse is due in the third cycle after the rising strobe change. The bench samples the second, third and fourth cycles, expecting the pulse only in the third. The active slots change on the edge after the pulse, so the bench compares all sixteen slots in the fourth cycle against a bench model of the shadow contents and the write count. The phase-detector disable output has no register in its path, so it is checked one time step after each bus change, with the strobe held high.

// File: rtl/nibld_pkg.sv
package nibld_pkg;

    localparam int NIB_W    = 4;
    localparam int NUM_REGS = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t addr;
        nib_t data;
    } wr_req_t;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_ADDR = 1'b1
    } cap_state_e;

    localparam int LDIV_SLOT = 5;
    localparam int CTRL_SLOT = 12;
    localparam int PD_SLOT   = 15;
    localparam int PD_BIT    = 3;

    function automatic nib_t por_value(input int idx);
        nib_t v;
        v = '0;
        if (idx == LDIV_SLOT) v = 4'b0001;
        if (idx == CTRL_SLOT) v = 4'b1000;
        return v;
    endfunction

    function automatic logic has_storage(input int idx);
        return !(idx == 13 || idx == 14);
    endfunction

    function automatic logic [NUM_REGS*NIB_W-1:0] por_vector();
        logic [NUM_REGS*NIB_W-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*NIB_W +: NIB_W] = por_value(i);
        return v;
    endfunction

endpackage

// File: rtl/nibld_strobe_sync.sv
module nibld_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
    assign rise_o = ~prev_q & sync_q[STAGES-1];

    // R1: a sample can only be one kind of edge
    a_r1_edge_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_o, rise_o}));

endmodule

// File: rtl/nibld_capture.sv
module nibld_capture
    import nibld_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_i,
    input  logic    rise_i,
    input  nib_t    bus_i,
    output logic    wr_valid_o,
    output wr_req_t wr_o,
    output nib_t    last_addr_o
);
    cap_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CAP_IDLE;
            wr_valid_o  <= 1'b0;
            wr_o        <= '0;
            last_addr_o <= '0;
        end else begin
            wr_valid_o <= 1'b0;
            if (fall_i) begin
                last_addr_o <= bus_i;
                state_q     <= CAP_ADDR;
            end else if (rise_i && state_q == CAP_ADDR) begin
                wr_valid_o <= 1'b1;
                wr_o.addr  <= last_addr_o;
                wr_o.data  <= bus_i;
                state_q    <= CAP_IDLE;
            end
        end
    end

    a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |=> !wr_valid_o);

    a_r1_pulse_after_rise: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> $past(rise_i));

endmodule

// File: rtl/nibld_bank.sv
module nibld_bank
    import nibld_pkg::*;
#(
    parameter int UNLOCK_WRITES = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_valid_i,
    input  wr_req_t                   wr_i,
    output logic [NUM_REGS*NIB_W-1:0] act_o,
    output logic                      unlocked_o
);
    localparam int CNT_W = $clog2(UNLOCK_WRITES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(UNLOCK_WRITES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            unlocked_o <= 1'b0;
        end else if (wr_valid_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX - 1'b1) unlocked_o <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (has_storage(i)) begin : g_store
            nib_t cell_q;
            always_ff @(posedge clk) begin
                if (wr_valid_i && wr_i.addr == nib_t'(i)) cell_q <= wr_i.data;
            end
            assign act_o[i*NIB_W +: NIB_W] = unlocked_o ? cell_q : por_value(i);
        end else begin : g_hole
            assign act_o[i*NIB_W +: NIB_W] = '0;
        end
    end

    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    a_r5_unlock_sticky: assert property (@(posedge clk) disable iff (rst)
        unlocked_o |=> unlocked_o);

    a_r5_cnt_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !wr_valid_i |=> $stable(cnt_q));

    a_r3_locked_below_count: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < CNT_MAX) |-> !unlocked_o);

endmodule

// File: rtl/nibld_top.sv
module nibld_top
    import nibld_pkg::*;
#(
    parameter int UNLOCK_WRITES = 32,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_i,
    input  logic [3:0]  bus_i,
    output logic [63:0] act_regs_o,
    output logic        pd_dis_o,
    output logic        wr_valid_o,
    output logic [3:0]  wr_addr_o,
    output logic [3:0]  wr_data_o
);
    logic    fall, rise, unlocked;
    wr_req_t wr;
    nib_t    last_addr;

    nibld_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .fall_o(fall), .rise_o(rise)
    );

    nibld_capture cap_i (
        .clk(clk), .rst(rst), .fall_i(fall), .rise_i(rise), .bus_i(bus_i),
        .wr_valid_o(wr_valid_o), .wr_o(wr), .last_addr_o(last_addr)
    );

    nibld_bank #(.UNLOCK_WRITES(UNLOCK_WRITES)) bank_i (
        .clk(clk), .rst(rst), .wr_valid_i(wr_valid_o), .wr_i(wr),
        .act_o(act_regs_o), .unlocked_o(unlocked)
    );

    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;
    assign pd_dis_o  = act_regs_o[PD_SLOT*NIB_W + PD_BIT]
                     & (last_addr == nib_t'(PD_SLOT)) & bus_i[PD_BIT];

    a_r3_por_until_unlock: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> act_regs_o == por_vector());

    a_r8_pd_quiet_when_locked: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !pd_dis_o);

endmodule

// File: tb/nibld_top_tb_top.sv
module nibld_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b1;
    logic [3:0]  bus = 4'h0;
    logic [63:0] act;
    logic        pd_dis, wr_valid;
    logic [3:0]  wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [3:0] exp_sh [16];

    always #4 clk = ~clk;

    nibld_top dut_i (
        .clk(clk), .rst(rst), .strobe_i(strobe), .bus_i(bus),
        .act_regs_o(act), .pd_dis_o(pd_dis), .wr_valid_o(wr_valid),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    function automatic logic [3:0] por_of(input int i);
        if (i == 5)  return 4'b0001;
        if (i == 12) return 4'b1000;
        return 4'b0000;
    endfunction

    function automatic logic [63:0] exp_act();
        logic [63:0] v;
        for (int i = 0; i < 16; i++) begin
            if (i == 13 || i == 14) v[i*4 +: 4] = 4'h0;
            else if (exp_cnt >= 32) v[i*4 +: 4] = exp_sh[i];
            else v[i*4 +: 4] = por_of(i);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d, input string req);
        @(negedge clk); bus = a;
        @(negedge clk); strobe = 1'b0;
        repeat (4) @(negedge clk);
        bus = d;
        @(negedge clk); strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(wr_valid == 1'b0, "R2 early", {63'd0, wr_valid}, 64'd0);
        @(negedge clk);
        chk(wr_valid == 1'b1 && wr_addr == a && wr_data == d, "R1/R2 pulse",
            {55'd0, wr_valid, wr_addr, wr_data}, {55'd0, 1'b1, a, d});
        if (exp_cnt < 32) exp_cnt++;
        if (!(a == 4'd13 || a == 4'd14)) exp_sh[a] = d;
        @(negedge clk);
        chk(wr_valid == 1'b0, "R2 late", {63'd0, wr_valid}, 64'd0);
        chk(act == exp_act(), req, act, exp_act());
    endtask

    task automatic pd_chk(input logic [3:0] b, input logic e, input string req);
        bus = b;
        #1;
        chk(pd_dis == e, req, {63'd0, pd_dis}, {63'd0, e});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(act == exp_act(), "R3 reset pattern", act, exp_act());
        chk(wr_valid == 1'b0 && pd_dis == 1'b0, "R3 idle outputs", {62'd0, wr_valid, pd_dis}, 64'd0);

        // fill every address once, still locked
        for (int i = 0; i < 16; i++) do_write(4'(i), 4'($urandom), "R3 locked fill");
        do_write(4'd13, 4'hF, "R6 hole while locked");
        for (int i = 0; i < 14; i++) do_write(4'($urandom), 4'($urandom), "R3 locked random");
        // write 32 unlocks
        do_write(4'd10, 4'hA, "R4 unlock write");
        for (int i = 0; i < 20; i++) do_write(4'($urandom), 4'($urandom), "R4 follow random");
        do_write(4'd14, 4'h7, "R6 hole discarded");
        do_write(4'd13, 4'h9, "R6 hole discarded");
        do_write(4'd10, 4'h5, "R7 reserved stored");

        do_write(4'd15, 4'b1000, "R8 enable set");
        pd_chk(4'b1000, 1'b1, "R8 pd high");
        pd_chk(4'b0000, 1'b0, "R8 pd follows bus low");
        pd_chk(4'b1111, 1'b1, "R8 pd follows bus high");
        do_write(4'd3, 4'h2, "R8 other address");
        pd_chk(4'b1000, 1'b0, "R8 needs last addr 15");
        do_write(4'd15, 4'b0000, "R8 enable clear");
        pd_chk(4'b1000, 1'b0, "R8 needs enable");

        // R9: reset keeps shadow contents
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; exp_cnt = 0;
        @(negedge clk);
        chk(act == exp_act(), "R9 reset restores pattern", act, exp_act());
        for (int i = 0; i < 31; i++) begin
            int a;
            a = i % 16;
            if (a == 7) a = 8;
            do_write(4'(a), 4'($urandom), "R9 relocked");
        end
        do_write(4'd2, 4'h6, "R9 old shadow kept");

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got=hung exp=done");
        summary();
        $finish;
    end

endmodule